// File: doc/BRIEF.md
# PHY Register Patch Sequencer

After reset, a PHY's internal control registers often need a handful of bit fields corrected before the link is brought up. This block holds a fixed list of such corrections. For every list entry it reads the register through a register-port master, keeps all bits outside the entry's clear mask, forces the bits of its set value, and writes the result back. The entries are applied one at a time, in a fixed order. After the last write has been acknowledged, the block waits a settle interval of about two microseconds and then raises `done`.

Software or a reset controller pulses `start` to launch the sequence. Each request leaves on a valid/ready channel. `req_valid` is raised with a stable address, direction and write data, and it stays asserted, with those fields unchanged, until the port answers with `req_ready` in the same cycle. The port may hold off a request for any number of cycles. Responses arrive on `rsp_valid` and are always accepted, so the port receives no back-pressure on that side. Only one request is outstanding at a time. A response flagged with `rsp_err` (a timeout of the register port) aborts the list. The block then raises `err` and reports the index of the entry that failed.

Top module: `phy_rmw_seq`

## Requirements
- R1: While reset is held and just after its release, `busy`, `done`, `err` and `req_valid` are 0.
- R2: Each entry is handled as one read followed by one write to the same address. The entries are applied at these addresses, in this order: 0x102D (index 0), 0x1010 (index 1), 0x1006 (index 2), 0x1002 (index 3), 0x0030 (index 4). `req_write` is 1 for a write and 0 for a read.
- R3: For 0x102D the write data is the read data with bit 7 set. For 0x1010 the write data is the read data with bits 11:4 cleared and bit 5 then set (OR of 0x20).
- R4: For 0x1006 the block clears bit 6 and sets bit 7, puts 3 into bits 10:8 and sets bit 11. For 0x1002 it puts 22 into bits 13:7 and 127 into bits 6:0, and sets bit 14. For 0x0030 it puts 8 into bits 7:4. In every case, all other bits keep their read value.
- R5: Once `req_valid` is raised, it stays high until `req_ready`, and `req_addr`, `req_write` and `req_wdata` stay unchanged over that time. No new request is raised while a response is still pending.
- R6: `done` rises exactly SETTLE_CYC = CLK_MHZ*SETTLE_NS/1000 clock cycles after the edge that accepts the last write response.
- R7: `done` stays high until the next `start`. That `start` is accepted: `done` drops and `busy` rises on the following edge.
- R8: A `start` while `busy` is high is ignored. The running list is neither restarted nor extended.
- R9: A response with `rsp_err` high aborts the sequence. After it, no further request is issued, `err` is 1, `err_index` holds the index of the entry whose read or write failed, and `done` stays 0. All of this holds until the next `start`, which clears `err`.
- R10: `busy` is high from the edge that accepts `start` until the edge that raises `done` or `err`. While not busy and without `start`, the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch the list; accepted only when not busy |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | List applied and settle time elapsed; held until next start |
| err | output | 1 | Sequence aborted by an error response; held until next start |
| err_index | output | 3 | Index of the entry that failed |
| req_valid | output | 1 | Request to the register port is valid |
| req_ready | input | 1 | Register port takes the request this cycle |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | 16 | Register address |
| req_wdata | output | 16 | Write data |
| rsp_valid | input | 1 | Response present (always accepted) |
| rsp_err | input | 1 | Response reports a port timeout |
| rsp_rdata | input | 16 | Read data of a read response |

## Verification
`req_valid` rises one edge after an accepted `start` and one edge after each accepted response that does not end the list. `err` rises on the very edge that accepts a failing response. `done` rises exactly SETTLE_CYC edges after the last write response. The bench drives and samples on falling edges and keeps a posedge counter. It stamps the cycle in which each response is consumed and the cycle in which `done` is first seen, and it compares their difference with the settle count derived from the clock frequency. The register-port model holds off `req_ready` and delays responses by amounts set in each vector, so that holding requests and strict one-at-a-time ordering are exercised under several timings.

// File: rtl/phy_rmw_pkg.sv
package phy_rmw_pkg;

  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 16;
  localparam int N_ENTRY = 5;
  localparam int IDX_W   = $clog2(N_ENTRY);

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] clr;
    logic [DATA_W-1:0] set;
  } rmw_entry_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_REQ,
    S_RD_WAIT,
    S_WR_REQ,
    S_WR_WAIT,
    S_SETTLE,
    S_DONE,
    S_FAIL
  } seq_state_t;

  // Patch list; the order is the application order.
  function automatic rmw_entry_t entry_at(input int unsigned i);
    rmw_entry_t e;
    case (i)
      0:       e = '{addr: 16'h102D, clr: 16'h0000, set: 16'h0080};
      1:       e = '{addr: 16'h1010, clr: 16'h0FF0, set: 16'h0020};
      2:       e = '{addr: 16'h1006, clr: 16'h0740, set: 16'h0B80};
      3:       e = '{addr: 16'h1002, clr: 16'h3FFF, set: 16'h4B7F};
      4:       e = '{addr: 16'h0030, clr: 16'h00F0, set: 16'h0080};
      default: e = '0;
    endcase
    return e;
  endfunction

  function automatic logic [DATA_W-1:0] apply_rmw(input logic [DATA_W-1:0] rd,
                                                  input rmw_entry_t e);
    return (rd & ~e.clr) | e.set;
  endfunction

endpackage

// File: rtl/phy_rmw_rom.sv
module phy_rmw_rom
  import phy_rmw_pkg::*;
#(
  parameter int ENTRIES = N_ENTRY,
  parameter int IW      = IDX_W
) (
  input  logic [IW-1:0] idx,
  output rmw_entry_t    ent
);

  rmw_entry_t table_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign table_q[g] = entry_at(g);
  end

  always_comb begin
    ent = '0;
    for (int k = 0; k < ENTRIES; k++) begin
      if (idx == IW'(k)) ent = table_q[k];
    end
  end

endmodule

// File: rtl/phy_rmw_settle.sv
module phy_rmw_settle #(
  parameter int CYCLES = 250,
  localparam int CNT_W = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= CNT_W'(CYCLES - 1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/phy_rmw_ctrl.sv
module phy_rmw_ctrl
  import phy_rmw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  rmw_entry_t        ent,
  input  logic              settle_expired,
  output logic              settle_load,
  output logic [IDX_W-1:0]  idx,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [IDX_W-1:0]  err_index,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_valid,
  input  logic              rsp_err,
  input  logic [DATA_W-1:0] rsp_rdata
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENTRY - 1);

  seq_state_t        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  fail_q;
  logic [DATA_W-1:0] wdata_q;
  logic              last_ok;

  assign last_ok     = rsp_valid && !rsp_err && (idx_q == LAST);
  assign settle_load = (state_q == S_WR_WAIT) && last_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      fail_q  <= '0;
      wdata_q <= '0;
    end else begin
      case (state_q)
        S_IDLE, S_DONE, S_FAIL: begin
          if (start) begin
            state_q <= S_RD_REQ;
            idx_q   <= '0;
            fail_q  <= '0;
          end
        end
        S_RD_REQ: begin
          if (req_ready) state_q <= S_RD_WAIT;
        end
        S_RD_WAIT: begin
          if (rsp_valid) begin
            if (rsp_err) begin
              state_q <= S_FAIL;
              fail_q  <= idx_q;
            end else begin
              wdata_q <= apply_rmw(rsp_rdata, ent);
              state_q <= S_WR_REQ;
            end
          end
        end
        S_WR_REQ: begin
          if (req_ready) state_q <= S_WR_WAIT;
        end
        S_WR_WAIT: begin
          if (rsp_valid) begin
            if (rsp_err) begin
              state_q <= S_FAIL;
              fail_q  <= idx_q;
            end else if (idx_q == LAST) begin
              state_q <= S_SETTLE;
            end else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= S_RD_REQ;
            end
          end
        end
        S_SETTLE: begin
          if (settle_expired) state_q <= S_DONE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign idx       = idx_q;
  assign req_valid = (state_q == S_RD_REQ) || (state_q == S_WR_REQ);
  assign req_write = (state_q == S_WR_REQ);
  assign req_wdata = wdata_q;
  assign done      = (state_q == S_DONE);
  assign err       = (state_q == S_FAIL);
  assign err_index = fail_q;
  assign busy      = !((state_q == S_IDLE) || (state_q == S_DONE) || (state_q == S_FAIL));

endmodule

// File: rtl/phy_rmw_seq.sv
module phy_rmw_seq
  import phy_rmw_pkg::*;
#(
  parameter int CLK_MHZ   = 125,
  parameter int SETTLE_NS = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [IDX_W-1:0]  err_index,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_valid,
  input  logic              rsp_err,
  input  logic [DATA_W-1:0] rsp_rdata
);

  localparam int RAW_CYC    = (CLK_MHZ * SETTLE_NS) / 1000;
  localparam int SETTLE_CYC = (RAW_CYC < 1) ? 1 : RAW_CYC;

  rmw_entry_t       ent;
  logic [IDX_W-1:0] idx;
  logic             settle_load;
  logic             settle_expired;

  phy_rmw_rom #(.ENTRIES(N_ENTRY), .IW(IDX_W)) u_rom (
    .idx (idx),
    .ent (ent)
  );

  phy_rmw_settle #(.CYCLES(SETTLE_CYC)) u_settle (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (settle_load),
    .expired (settle_expired)
  );

  phy_rmw_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (start),
    .ent            (ent),
    .settle_expired (settle_expired),
    .settle_load    (settle_load),
    .idx            (idx),
    .busy           (busy),
    .done           (done),
    .err            (err),
    .err_index      (err_index),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_write      (req_write),
    .req_wdata      (req_wdata),
    .rsp_valid      (rsp_valid),
    .rsp_err        (rsp_err),
    .rsp_rdata      (rsp_rdata)
  );

  assign req_addr = ent.addr;

endmodule

// File: rtl/phy_rmw_seq_chk.sv
module phy_rmw_seq_chk
  import phy_rmw_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [IDX_W-1:0]  err_index,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid
);

  logic              pending_q;
  logic              want_wr_q;
  logic [ADDR_W-1:0] rd_addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      want_wr_q <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      if (req_valid && req_ready) pending_q <= 1'b1;
      else if (rsp_valid)         pending_q <= 1'b0;
      if (req_valid && req_ready) begin
        want_wr_q <= !req_write;
        rd_addr_q <= req_addr;
      end
      if (start && !busy) want_wr_q <= 1'b0;
    end
  end

  a_r5_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_write) && $stable(req_wdata));

  a_r5_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    pending_q |-> !req_valid);

  a_r2_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && want_wr_q |-> req_write && (req_addr == rd_addr_q));

  a_r6_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !req_valid && !err);

  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);

  a_r9_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !req_valid && !busy);

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err && !start |=> err && $stable(err_index));

  a_r10_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> !busy);

endmodule

bind phy_rmw_seq phy_rmw_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .err_index (err_index),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .rsp_valid (rsp_valid)
);

// File: tb/phy_rmw_seq_tb.sv
module phy_rmw_seq_tb;

  localparam int CLK_MHZ   = 125;
  localparam int SETTLE_NS = 2000;
  localparam int EXP_SETTLE = CLK_MHZ * SETTLE_NS / 1000;

  typedef struct packed {
    logic [0:4][15:0] init;
    logic [3:0]       gap;
    logic [3:0]       lat;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{init: {16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000}, gap: 4'd0, lat: 4'd0},
    '{init: {16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF}, gap: 4'd2, lat: 4'd1},
    '{init: {16'hA5A5, 16'h5A5A, 16'hA5A5, 16'h5A5A, 16'hA5A5}, gap: 4'd1, lat: 4'd3},
    '{init: {16'h8001, 16'hF00F, 16'h0F40, 16'hC000, 16'h1234}, gap: 4'd3, lat: 4'd0}
  };

  localparam logic [15:0] ADDRS [5] = '{16'h102D, 16'h1010, 16'h1006, 16'h1002, 16'h0030};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        busy, done, err;
  logic [2:0]  err_index;
  logic        req_valid, req_write;
  logic        req_ready = 1'b0;
  logic [15:0] req_addr, req_wdata;
  logic        rsp_valid = 1'b0;
  logic        rsp_err = 1'b0;
  logic [15:0] rsp_rdata = '0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [15:0] mem [5];
  logic [15:0] log_addr [32];
  logic        log_wr   [32];
  logic [15:0] log_data [32];
  int          n_txn = 0;
  int          r_gap = 0;
  int          r_lat = 0;
  int          r_err_at = -1;
  int          last_rsp_cyc = 0;
  int          done_cyc = -1;
  int          hold_bad = 0;

  phy_rmw_seq #(.CLK_MHZ(CLK_MHZ), .SETTLE_NS(SETTLE_NS)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .err_index (err_index),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int slot_of(input logic [15:0] a);
    case (a)
      16'h102D: return 0;
      16'h1010: return 1;
      16'h1006: return 2;
      16'h1002: return 3;
      16'h0030: return 4;
      default:  return -1;
    endcase
  endfunction

  // Expected write value built field by field from R3 and R4.
  function automatic logic [15:0] exp_wr(input int s, input logic [15:0] v);
    logic [15:0] r;
    r = v;
    case (s)
      0: r[7] = 1'b1;
      1: begin r[11:4] = 8'h00; r = r | 16'h0020; end
      2: begin r[6] = 1'b0; r[7] = 1'b1; r[10:8] = 3'd3; r[11] = 1'b1; end
      3: begin r[13:7] = 7'd22; r[6:0] = 7'd127; r[14] = 1'b1; end
      default: r[7:4] = 4'd8;
    endcase
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Register-port model: drives at falling edges.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && req_valid) begin
        logic [15:0] a0;
        logic [15:0] d0;
        logic        w0;
        int          s;
        a0 = req_addr; d0 = req_wdata; w0 = req_write;
        repeat (r_gap) @(negedge clk);
        if (req_addr !== a0 || req_wdata !== d0 || req_write !== w0) hold_bad++;
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        log_addr[n_txn] = a0;
        log_wr[n_txn]   = w0;
        log_data[n_txn] = d0;
        repeat (r_lat) @(negedge clk);
        s = slot_of(a0);
        rsp_err   = (n_txn == r_err_at);
        rsp_rdata = (s >= 0) ? mem[s] : 16'h0000;
        if (w0 && !rsp_err && s >= 0) mem[s] = d0;
        rsp_valid = 1'b1;
        last_rsp_cyc = cyc + 1;
        if (n_txn < 31) n_txn++;
        @(negedge clk);
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
      end
    end
  end

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic run_seq(input int gap, input int lat, input int err_at,
                         input logic [0:4][15:0] init);
    int w;
    for (int s = 0; s < 5; s++) mem[s] = init[s];
    n_txn = 0; r_gap = gap; r_lat = lat; r_err_at = err_at;
    done_cyc = -1; hold_bad = 0;
    pulse_start();
    w = 0;
    while (!done && !err && w < 5000) begin
      @(negedge clk);
      w++;
    end
    if (done) done_cyc = cyc;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    // R1 reset state
    repeat (3) @(negedge clk);
    check(!busy && !done && !err && !req_valid, "R1 in reset", {busy, done, err, req_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !done && !err && !req_valid, "R1 after reset", {busy, done, err, req_valid}, 0);

    // Vector table
    for (int v = 0; v < 4; v++) begin
      run_seq(VECS[v].gap, VECS[v].lat, -1, VECS[v].init);
      check(done == 1'b1 && err == 1'b0, "R6 done reached", {done, err}, 2);
      check(n_txn == 10, "R2 transaction count", n_txn, 10);
      for (int k = 0; k < 10; k++) begin
        check(log_addr[k] == ADDRS[k/2] && log_wr[k] == k[0], "R2 order",
              {log_wr[k], log_addr[k]}, {k[0], ADDRS[k/2]});
        if (k[0]) begin
          if (k / 2 < 2)
            check(log_data[k] == exp_wr(k/2, VECS[v].init[k/2]), "R3 write data",
                  log_data[k], exp_wr(k/2, VECS[v].init[k/2]));
          else
            check(log_data[k] == exp_wr(k/2, VECS[v].init[k/2]), "R4 write data",
                  log_data[k], exp_wr(k/2, VECS[v].init[k/2]));
        end
      end
      check(hold_bad == 0, "R5 request held until ready", hold_bad, 0);
      check(done_cyc - last_rsp_cyc == EXP_SETTLE, "R6 settle cycles",
            done_cyc - last_rsp_cyc, EXP_SETTLE);
    end

    // R7: done held, next start accepted
    repeat (20) @(negedge clk);
    check(done == 1'b1 && busy == 1'b0, "R7 done held", {done, busy}, 2);
    for (int s = 0; s < 5; s++) mem[s] = 16'h0000;
    n_txn = 0; r_gap = 0; r_lat = 0; r_err_at = -1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(done == 1'b0 && busy == 1'b1, "R7 R10 restart from done", {done, busy}, 1);
    while (!done) @(negedge clk);

    // R8: start while busy ignored
    fork
      run_seq(1, 2, -1, VECS[2].init);
      begin
        wait (n_txn == 3);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
      end
    join
    check(n_txn == 10, "R8 no restart count", n_txn, 10);
    check(log_addr[4] == 16'h1006 && log_addr[9] == 16'h0030, "R8 list not restarted",
          log_addr[4], 16'h1006);
    check(done == 1'b1, "R8 completes", done, 1);

    // R9: failure on read of entry 2 (transaction 4)
    run_seq(0, 1, 4, VECS[1].init);
    check(err == 1'b1 && done == 1'b0 && busy == 1'b0, "R9 err raised", {err, done, busy}, 4);
    check(err_index == 3'd2, "R9 err_index read fail", err_index, 2);
    repeat (30) @(negedge clk);
    check(n_txn == 5 && !req_valid, "R9 no further request", n_txn, 5);
    check(err == 1'b1 && err_index == 3'd2 && done == 1'b0, "R9 err held", {err, err_index}, 10);

    // R9: failure on write of entry 4 (transaction 9)
    run_seq(2, 0, 9, VECS[3].init);
    check(err == 1'b1 && err_index == 3'd4, "R9 err_index write fail", err_index, 4);
    repeat (300) @(negedge clk);
    check(done == 1'b0 && n_txn == 10, "R9 no done after abort", {done, n_txn[4:0]}, 10);

    // R9 R10: start clears err
    r_err_at = -1; n_txn = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(err == 1'b0 && busy == 1'b1, "R9 R10 start clears err", {err, busy}, 1);
    while (!done) @(negedge clk);
    check(n_txn == 10, "R10 full run after error", n_txn, 10);

    // R1 reset mid-sequence
    pulse_start();
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!busy && !done && !err && !req_valid, "R1 reset mid-run", {busy, done, err, req_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !req_valid, "R1 R10 idle after reset", {busy, req_valid}, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule